// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block holds the time of day and the calendar as packed BCD bytes: seconds, minutes, hours, day of week, date of month, month (with a century flag in its top bit) and a two-digit year. A free-running tick input is divided by a parameterised prescaler, and every `PRESCALE`-th tick advances the seconds counter. Carries then ripple through minutes, hours, the date and day of week, month and year, with month lengths and leap years taken into account.

The hours byte works in either a 24-hour or a 12-hour format. A format flag and an AM/PM flag sit inside the byte. A register front end writes any field through a parallel load port and reads all seven fields continuously. An alarm comparator reads them too, and it uses the one-cycle update strobe to sample the fields in the cycle they take new values.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour), day of week 0x01, date 0x01, month 0x01 (century bit 0) and year 0x00, and `upd_o` is low.
- R2: The fields advance by one second on every `PRESCALE`-th cycle in which `tick_i` is high and no write occurs. The fields hold in all other cycles. `upd_o` is high for exactly the one cycle in which the advanced values first appear.
- R3: Seconds and minutes count 00 to 59 in BCD, per digit (x9 goes to (x+1)0). Wrapping from 59 to 00 advances the next field.
- R4: When hours bit 6 is 0 (24-hour), hours count 00 to 23 in BCD. The step from 23 to 00 advances the date and the day of week.
- R5: When hours bit 6 is 1 (12-hour), bit 5 is the PM flag and bits 4:0 hold 01 to 12 in BCD. 11 AM (0x51) steps to 12 PM (0x72). 12 steps to 01 with the flag kept. 11 PM (0x71) steps to 12 AM (0x52) and advances the date and the day of week.
- R6: Day of week counts 1 to 7 and returns to 1, stepping together with the date.
- R7: The date returns to 01 and the month advances after day 31 in months 01, 03, 05, 07, 08, 10 and 12, and after day 30 in months 04, 06, 09 and 11.
- R8: February ends at day 29 when the year value is a multiple of 4 (00, 04, …, 96), and at day 28 otherwise.
- R9: Month counts 01 to 12. The step from 12 to 01 advances the year. The step from year 99 to 00 inverts month bit 7 (century).
- R10: A write with `wr_en_i` high loads `wr_data_i` into the field chosen by `wr_sel_i`: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year. Bits that are always zero read 0: bit 7 of seconds, minutes and hours, bits 7:3 of day of week, bits 7:6 of date, and bits 6:5 of month.
- R11: In a write cycle, only the written field changes. A second step due in that cycle is dropped and `upd_o` stays low the next cycle. A write to seconds also restarts the prescaler, so the next advance needs `PRESCALE` further ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Sub-second tick, one cycle per pulse |
| wr_en_i | input | 1 | Load strobe for one field |
| wr_sel_i | input | 3 | Field select for the load |
| wr_data_i | input | 8 | Value to load |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hours with format and PM flags |
| dow_o | output | 8 | Day of week 1..7 |
| date_o | output | 8 | Date of month, BCD |
| month_o | output | 8 | Month BCD, bit 7 century |
| year_o | output | 8 | Year 00..99, BCD |
| upd_o | output | 1 | One-cycle strobe after a second step |

## Verification
On every cycle, the assertions check the following:
- The fields stay frozen without a step.
- A step always raises the strobe and changes the seconds.
- Minutes hold unless seconds wrap.
- A write suppresses the strobe and loads the masked seconds value.
- The 11 PM to midnight and end-of-century transitions produce the expected encodings.

Other behaviour can only be shown by the bench's scenarios, which compare every field against an independent binary model of the calendar:
- month lengths in every month,
- February in leap and common years,
- the per-digit carries,
- day-of-week wrap,
- the phase restart after a seconds write,
- the loss of a step that collides with a write.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

  typedef enum logic [2:0] {
    SEL_SEC   = 3'd0,
    SEL_MIN   = 3'd1,
    SEL_HOUR  = 3'd2,
    SEL_DOW   = 3'd3,
    SEL_DATE  = 3'd4,
    SEL_MONTH = 3'd5,
    SEL_YEAR  = 3'd6
  } field_sel_e;

  localparam logic [7:0] MASK_SEC   = 8'h7F;
  localparam logic [7:0] MASK_MIN   = 8'h7F;
  localparam logic [7:0] MASK_HOUR  = 8'h7F;
  localparam logic [7:0] MASK_DOW   = 8'h07;
  localparam logic [7:0] MASK_DATE  = 8'h3F;
  localparam logic [7:0] MASK_MONTH = 8'h9F;

  typedef struct packed {
    logic       carry;
    logic [7:0] val;
  } bcd_step_t;

  // Increment a packed BCD byte digit by digit, wrapping to 00 after last.
  function automatic bcd_step_t bcd_step(input logic [7:0] v, input logic [7:0] last);
    bcd_step_t r;
    r.carry = 1'b0;
    if (v >= last) begin
      r.val   = 8'h00;
      r.carry = 1'b1;
    end else if (v[3:0] >= 4'h9) begin
      r.val = {v[7:4] + 4'h1, 4'h0};
    end else begin
      r.val = {v[7:4], v[3:0] + 4'h1};
    end
    return r;
  endfunction

  // Hours byte step in either format; carry means a new day begins.
  function automatic bcd_step_t hour_step(input logic [7:0] h);
    bcd_step_t r;
    r.carry = 1'b0;
    r.val   = h;
    if (h[6]) begin
      if (h[4:0] == 5'h12) begin
        r.val = {h[7:5], 5'h01};
      end else if (h[4:0] == 5'h11) begin
        r.val   = {h[7:6], ~h[5], 5'h12};
        r.carry = h[5];
      end else if (h[3:0] >= 4'h9) begin
        r.val = {h[7:5], 1'b1, 4'h0};
      end else begin
        r.val = {h[7:4], h[3:0] + 4'h1};
      end
    end else begin
      r = bcd_step({2'b00, h[5:0]}, 8'h23);
    end
    return r;
  endfunction

  // Multiple of four: 2*(tens mod 2) + units, taken mod 4.
  function automatic logic is_leap(input logic [7:0] yr);
    logic [1:0] m;
    m = {yr[4], 1'b0} + yr[1:0];
    return (m == 2'd0);
  endfunction

  function automatic logic [5:0] last_date(input logic [4:0] mon, input logic [7:0] yr);
    logic [5:0] d;
    case (mon)
      5'h02:                      d = is_leap(yr) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: d = 6'h30;
      default:                    d = 6'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_tick_prescale.sv
module rtc_tick_prescale #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic phase_clr_i,
  output logic step_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  generate
    if (PRESCALE == 1) begin : g_direct
      assign step_o = tick_i;
    end else begin : g_divide
      logic [PW-1:0] phase_q;
      assign step_o = tick_i && (phase_q == LAST);
      always_ff @(posedge clk) begin
        if (!rst_n)           phase_q <= '0;
        else if (phase_clr_i) phase_q <= '0;
        else if (tick_i)      phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       min_adv_o,
  output logic       hour_adv_o,
  output logic       day_adv_o
);
  logic [7:0] sec_q, min_q, hour_q;
  bcd_step_t  sec_nx, min_nx, hour_nx;

  always_comb begin
    sec_nx  = bcd_step(sec_q, 8'h59);
    min_nx  = bcd_step(min_q, 8'h59);
    hour_nx = hour_step(hour_q);
  end

  assign min_adv_o  = adv_i && sec_nx.carry;
  assign hour_adv_o = min_adv_o && min_nx.carry;
  assign day_adv_o  = hour_adv_o && hour_nx.carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_SEC:  sec_q  <= wr_data_i & MASK_SEC;
        SEL_MIN:  min_q  <= wr_data_i & MASK_MIN;
        SEL_HOUR: hour_q <= wr_data_i & MASK_HOUR;
        default:  ;
      endcase
    end else begin
      if (adv_i)      sec_q  <= sec_nx.val;
      if (min_adv_o)  min_q  <= min_nx.val;
      if (hour_adv_o) hour_q <= hour_nx.val;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
endmodule

// File: rtl/rtc_date_chain.sv
module rtc_date_chain
  import rtc_cal_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_adv_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       month_adv_o,
  output logic       year_adv_o
);
  logic [2:0] dow_q;
  logic [5:0] date_q;
  logic [4:0] mon_q;
  logic       cent_q;
  logic [7:0] year_q;
  logic [5:0] date_last;
  bcd_step_t  date_nx, mon_nx, year_nx;

  always_comb begin
    date_last = last_date(mon_q, year_q);
    date_nx   = bcd_step({2'b00, date_q}, {2'b00, date_last});
    mon_nx    = bcd_step({3'b000, mon_q}, 8'h12);
    year_nx   = bcd_step(year_q, 8'h99);
  end

  assign month_adv_o = day_adv_i && date_nx.carry;
  assign year_adv_o  = month_adv_o && mon_nx.carry;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dow_q  <= 3'd1;
      date_q <= 6'h01;
      mon_q  <= 5'h01;
      cent_q <= 1'b0;
      year_q <= 8'h00;
    end else if (wr_en_i) begin
      case (wr_sel_i)
        SEL_DOW:   dow_q  <= wr_data_i[2:0];
        SEL_DATE:  date_q <= wr_data_i[5:0];
        SEL_MONTH: begin
          cent_q <= wr_data_i[7];
          mon_q  <= wr_data_i[4:0];
        end
        SEL_YEAR:  year_q <= wr_data_i;
        default:   ;
      endcase
    end else begin
      if (day_adv_i) begin
        dow_q  <= (dow_q >= 3'd7) ? 3'd1 : dow_q + 3'd1;
        date_q <= date_nx.carry ? 6'h01 : date_nx.val[5:0];
      end
      if (month_adv_o) mon_q <= mon_nx.carry ? 5'h01 : mon_nx.val[4:0];
      if (year_adv_o) begin
        year_q <= year_nx.val;
        if (year_nx.carry) cent_q <= ~cent_q;
      end
    end
  end

  assign dow_o   = {5'b0, dow_q};
  assign date_o  = {2'b0, date_q};
  assign month_o = {cent_q, 2'b00, mon_q};
  assign year_o  = year_q;
endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_cal_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [2:0] wr_sel_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic [7:0] dow_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o,
  output logic       upd_o
);
  logic sec_step;
  logic sec_adv;
  logic phase_clr;
  logic min_adv, hour_adv, day_adv, month_adv, year_adv;
  logic upd_q;

  assign phase_clr = wr_en_i && (wr_sel_i == SEL_SEC);
  assign sec_adv   = sec_step && !wr_en_i;

  rtc_tick_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .phase_clr_i(phase_clr), .step_o(sec_step)
  );

  rtc_time_chain u_time (
    .clk(clk), .rst_n(rst_n), .adv_i(sec_adv),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .min_adv_o(min_adv), .hour_adv_o(hour_adv), .day_adv_o(day_adv)
  );

  rtc_date_chain u_date (
    .clk(clk), .rst_n(rst_n), .day_adv_i(day_adv),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .dow_o(dow_o), .date_o(date_o), .month_o(month_o), .year_o(year_o),
    .month_adv_o(month_adv), .year_adv_o(year_adv)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= sec_adv;
  end

  assign upd_o = upd_q;
endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en_i,
  input logic [2:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic       sec_step,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] dow_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic       upd_o
);
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_step && !wr_en_i) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o) &&
      $stable(dow_o) && $stable(date_o) && $stable(month_o) && $stable(year_o) && !upd_o));

  assert_step_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && !wr_en_i) |=> (upd_o && (sec_o != $past(sec_o))));

  assert_min_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && !wr_en_i && sec_o != 8'h59) |=> $stable(min_o));

  assert_midnight12_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && !wr_en_i && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h71)
      |=> (hour_o == 8'h52 && date_o != $past(date_o)));

  assert_century_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_step && !wr_en_i && sec_o == 8'h59 && min_o == 8'h59 && hour_o == 8'h23 &&
     date_o == 8'h31 && month_o[4:0] == 5'h12 && year_o == 8'h99)
      |=> (year_o == 8'h00 && month_o[4:0] == 5'h01 && month_o[7] != $past(month_o[7])));

  assert_sec_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i == 3'd0) |=> (sec_o == ($past(wr_data_i) & 8'h7F)));

  assert_write_no_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> !upd_o);
endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_data_i(wr_data_i), .sec_step(sec_step), .sec_o(sec_o), .min_o(min_o),
  .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .month_o(month_o),
  .year_o(year_o), .upd_o(upd_o)
);

// File: tb/rtc_bcd_calendar_tb_top.sv
module rtc_bcd_calendar_tb_top;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = 3'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, dow_o, date_o, month_o, year_o;
  logic       upd_o;

  always #4 clk = ~clk;

  rtc_bcd_calendar #(.PRESCALE(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .sec_o(sec_o), .min_o(min_o),
    .hour_o(hour_o), .dow_o(dow_o), .date_o(date_o), .month_o(month_o),
    .year_o(year_o), .upd_o(upd_o)
  );

  int n_vec = 0;
  int n_err = 0;
  logic [55:0] exp_q[$];
  string       tag_q[$];

  // Binary reference model of the calendar.
  int ms = 0, mm = 0, mh = 0, mdow = 1, md = 1, mmo = 1, my = 0, mph = 0;
  bit m12 = 0, mcent = 0;

  function automatic logic [7:0] to_bcd(input int v);
    logic [7:0] r;
    r[7:4] = 4'(v / 10);
    r[3:0] = 4'(v % 10);
    return r;
  endfunction

  function automatic int from_bcd(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int month_len(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [55:0] model_vec();
    logic [7:0] hb;
    int h12;
    if (m12) begin
      h12 = (mh % 12 == 0) ? 12 : mh % 12;
      hb = 8'h40 | (mh >= 12 ? 8'h20 : 8'h00) | to_bcd(h12);
    end else hb = to_bcd(mh);
    return {to_bcd(my), {mcent, 7'b0} | to_bcd(mmo), to_bcd(md), to_bcd(mdow),
            hb, to_bcd(mm), to_bcd(ms)};
  endfunction

  function automatic logic [55:0] dut_vec();
    return {year_o, month_o, date_o, dow_o, hour_o, min_o, sec_o};
  endfunction

  task automatic compare(input logic [55:0] exp, input string tag);
    logic [55:0] got;
    got = dut_vec();
    n_vec++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_second();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          mdow = (mdow == 7) ? 1 : mdow + 1;
          md++;
          if (md > month_len(mmo, my)) begin
            md = 1; mmo++;
            if (mmo > 12) begin
              mmo = 1; my++;
              if (my > 99) begin my = 0; mcent = ~mcent; end
            end
          end
        end
      end
    end
  endtask

  // Driver: one tick pulse; expected result goes to the scoreboard queue.
  task automatic pulse(input string tag);
    tick_i = 1'b1;
    if (mph == P - 1) begin
      mph = 0;
      model_second();
      exp_q.push_back(model_vec());
      tag_q.push_back(tag);
    end else mph++;
    @(negedge clk);
    tick_i = 1'b0;
  endtask

  task automatic run_seconds(input int n, input string tag);
    repeat (n * P) pulse(tag);
  endtask

  task automatic idle_check(input int n, input string tag);
    repeat (n) @(negedge clk);
    compare(model_vec(), tag);
  endtask

  task automatic write_field(input int sel, input logic [7:0] d, input bit with_tick,
                             input string tag);
    logic [7:0] mk;
    wr_en_i = 1'b1; wr_sel_i = 3'(sel); wr_data_i = d; tick_i = with_tick;
    case (sel)
      0: begin mk = d & 8'h7F; ms = from_bcd(mk); end
      1: begin mk = d & 8'h7F; mm = from_bcd(mk); end
      2: begin
        mk = d & 8'h7F;
        m12 = mk[6];
        if (mk[6]) mh = ((int'(mk[4]) * 10 + int'(mk[3:0])) % 12) + (mk[5] ? 12 : 0);
        else mh = int'(mk[5:4]) * 10 + int'(mk[3:0]);
      end
      3: begin mk = d & 8'h07; mdow = int'(mk); end
      4: begin mk = d & 8'h3F; md = from_bcd(mk); end
      5: begin mk = d & 8'h9F; mcent = mk[7]; mmo = from_bcd({3'b0, mk[4:0]}); end
      default: begin my = from_bcd(d); end
    endcase
    if (sel == 0) mph = 0;
    else if (with_tick) mph = (mph == P - 1) ? 0 : mph + 1;
    @(negedge clk);
    wr_en_i = 1'b0; tick_i = 1'b0;
    compare(model_vec(), tag);
  endtask

  task automatic set_all(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                         input logic [7:0] h, input logic [7:0] mi, input logic [7:0] s,
                         input string tag);
    write_field(6, y, 0, tag);
    write_field(5, mo, 0, tag);
    write_field(4, d, 0, tag);
    write_field(2, h, 0, tag);
    write_field(1, mi, 0, tag);
    write_field(0, s, 0, tag);
  endtask

  // Monitor: pops the scoreboard whenever the design raises its strobe.
  always @(negedge clk) begin
    if (rst_n && upd_o) begin
      if (exp_q.size() == 0) begin
        n_vec++; n_err++;
        $display("FAIL R2: got unexpected update strobe expected none");
      end else begin
        compare(exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare(model_vec(), "R1 reset values");
    n_vec++;
    if (upd_o !== 1'b0) begin n_err++; $display("FAIL R1: got upd %b expected 0", upd_o); end

    // R2: prescaled advance
    repeat (P - 1) pulse("R2 no step");
    idle_check(2, "R2 hold before step");
    run_seconds(3, "R2 step");
    idle_check(3, "R2 hold after step");

    // R11: seconds write restarts phase; write beats a due step
    pulse("R11 phase"); pulse("R11 phase");
    write_field(0, 8'h10, 0, "R11 sec write clears phase");
    repeat (P - 1) pulse("R11 after clear");
    idle_check(1, "R11 no step yet");
    pulse("R11 first step after clear");
    repeat (P - 1) pulse("R11 approach");
    write_field(1, 8'h05, 1, "R11 write drops step");
    idle_check(2, "R11 step lost");
    run_seconds(2, "R11 resume");

    // R3: digit carries and 59 wrap
    write_field(0, 8'h57, 0, "R3 set");
    run_seconds(4, "R3 sec wrap");
    write_field(0, 8'h08, 0, "R3 set");
    run_seconds(2, "R3 units carry");
    write_field(1, 8'h59, 0, "R3 set"); write_field(0, 8'h58, 0, "R3 set");
    run_seconds(3, "R3 min wrap");

    // R4: 24-hour
    set_all(8'h21, 8'h03, 8'h14, 8'h09, 8'h59, 8'h59, "R4 set");
    run_seconds(1, "R4 09 to 10");
    write_field(2, 8'h23, 0, "R4 set"); write_field(1, 8'h59, 0, "R4 set");
    write_field(0, 8'h59, 0, "R4 set");
    run_seconds(2, "R4 23 to 00 day carry");

    // R5: 12-hour
    set_all(8'h21, 8'h03, 8'h10, 8'h51, 8'h59, 8'h59, "R5 set");
    run_seconds(1, "R5 11AM to 12PM");
    write_field(1, 8'h59, 0, "R5 set"); write_field(0, 8'h59, 0, "R5 set");
    run_seconds(1, "R5 12PM to 1PM");
    write_field(2, 8'h49, 0, "R5 set"); write_field(1, 8'h59, 0, "R5 set");
    write_field(0, 8'h59, 0, "R5 set");
    run_seconds(1, "R5 9AM to 10AM");
    write_field(2, 8'h71, 0, "R5 set"); write_field(1, 8'h59, 0, "R5 set");
    write_field(0, 8'h59, 0, "R5 set");
    run_seconds(1, "R5 11PM to 12AM");

    // R6: day of week wrap
    write_field(3, 8'h07, 0, "R6 set");
    set_all(8'h21, 8'h04, 8'h02, 8'h23, 8'h59, 8'h59, "R6 set");
    run_seconds(1, "R6 dow 7 to 1");

    // R7: every month end in a common year
    for (int mo = 1; mo <= 12; mo++) begin
      set_all(8'h01, to_bcd(mo), to_bcd(month_len(mo, 1)), 8'h23, 8'h59, 8'h59, "R7 set");
      run_seconds(1, "R7 month end");
    end

    // R8: February across year kinds
    set_all(8'h04, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, "R8 set");
    run_seconds(1, "R8 leap 28 to 29");
    write_field(2, 8'h23, 0, "R8 set"); write_field(1, 8'h59, 0, "R8 set");
    write_field(0, 8'h59, 0, "R8 set");
    run_seconds(1, "R8 leap 29 to Mar");
    set_all(8'h10, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, "R8 set");
    run_seconds(1, "R8 year 10 common");
    set_all(8'h96, 8'h02, 8'h28, 8'h23, 8'h59, 8'h59, "R8 set");
    run_seconds(1, "R8 year 96 leap");
    set_all(8'h00, 8'h02, 8'h29, 8'h23, 8'h59, 8'h59, "R8 set");
    run_seconds(1, "R8 year 00 leap");

    // R9: year and century wrap
    set_all(8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, "R9 set");
    run_seconds(1, "R9 century set");
    set_all(8'h99, 8'h92, 8'h31, 8'h23, 8'h59, 8'h59, "R9 set");
    run_seconds(1, "R9 century clear");
    set_all(8'h41, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59, "R9 set");
    run_seconds(1, "R9 year step");

    // R10: masked loads
    write_field(0, 8'hD9, 0, "R10 sec mask");
    write_field(1, 8'h92, 0, "R10 min mask");
    write_field(2, 8'hA3, 0, "R10 hour mask");
    write_field(3, 8'hFD, 0, "R10 dow mask");
    write_field(4, 8'hF1, 0, "R10 date mask");
    write_field(5, 8'hE5, 0, "R10 month mask");
    write_field(6, 8'h37, 0, "R10 year load");
    run_seconds(1, "R10 after loads");

    idle_check(4, "R2 final hold");
    n_vec++;
    if (exp_q.size() != 0) begin
      n_err++;
      $display("FAIL R2: got %0d pending updates expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule